// File: doc/BRIEF.md
# Tunable Complex Downconversion Mixer

This block moves a chosen slice of spectrum in a real sampled stream down to DC. A numerically controlled oscillator, a phase register advanced by a tuning step, drives a folded quarter-wave amplitude table. The table yields a cosine and a sine for the same phase value on the same cycle. Each incoming real sample is multiplied by both. The cosine product forms the in-phase stream and the sine product forms the quadrature stream. Both products are rounded to the output width.

The tuning step is a two's-complement number, so the oscillator can run at a negative or a positive frequency. Take a tone that undersampling folds to a positive alias. A negative step brings that alias to DC, but the neighbouring channels come out in reversed order. A positive step of the same size brings the tone's negative-frequency image to DC instead, with the neighbours in their true order. Software converts a desired frequency into a step; one step unit is the sample rate divided by 2^25. A clock enable lets the sample rate run below the clock rate. Every register in the block advances only on an enabled cycle.

Top module: `nco_downmixer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `iq_valid` is 0, `i_out` and `q_out` are 0, and the 25-bit phase is 0.
- R2: On each cycle with `clk_en` high, the phase becomes (phase + `tune_word`) mod 2^25, where `tune_word` is read as signed. The sample taken on the k-th enabled cycle after reset (k from 0) uses the sum of the tuning words of the earlier enabled cycles.
- R3: Let p be the top 12 bits of the phase (phase >> 13). The sine amplitude is S(p) = round(32767·sin(2π(p+0.5)/4096)), with the magnitude rounded half up and the sign applied afterwards. The cosine on that cycle is S((p+1024) mod 4096), taken from the same phase value.
- R4: `i_out` = floor((C·x + 4096)/8192) and `q_out` = floor((S·x + 4096)/8192), where x is the signed input sample and C and S are the cosine and sine amplitudes.
- R5: A sample accepted on an enabled cycle appears on the outputs after the fourth enabled clock edge, counting the edge that accepts it. `iq_valid` carries that sample's `adc_valid`.
- R6: On a cycle with `clk_en` low, the phase, the pipeline, `i_out`, `q_out` and `iq_valid` all keep their values.
- R7: A new `tune_word` is used from the first enabled edge at which it is presented. The phase already accumulated is kept and is not cleared.
- R8: A negative `tune_word` makes the phase decrease modulo 2^25, so the oscillator runs at a negative frequency.
- R9: A sample with `adc_valid` low produces `iq_valid` low in its output slot. The phase still advances on that cycle.
- R10: Full-scale inputs, −8192 and +8191, give correct rounded results with no wrap. Neither output ever takes the value −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Sample-rate enable; tie high when the sample rate equals the clock rate |
| tune_word | input | 25 | Signed phase step per enabled cycle |
| adc_data | input | 14 | Signed real input sample |
| adc_valid | input | 1 | Marks `adc_data` as a real sample |
| i_out | output | 16 | Signed in-phase product, rounded |
| q_out | output | 16 | Signed quadrature product, rounded |
| iq_valid | output | 1 | Marks `i_out` and `q_out` as valid |

## Verification
The bench builds the block with its default parameters: a 25-bit phase, a 1024-entry quarter table, 16-bit amplitudes, 14-bit input and 16-bit output. With a 1024-entry table, a tuning step of 2^23 visits each quadrant boundary of the fold exactly. With a 14-bit input, the full-scale negative sample meets the largest cosine value, the one product that can come near output wrap. The bench compares the outputs against an independent per-cycle model of the phase and of the sine formula. It runs positive, negative and mid-stream changed tuning steps, gaps in the enable and gaps in valid.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

    localparam int PHASE_W_DEF = 25;
    localparam int LUT_AW_DEF  = 10;
    localparam int AMP_W_DEF   = 16;
    localparam int IN_W_DEF    = 14;
    localparam int OUT_W_DEF   = 16;
    localparam int PIPE_LAT    = 4;

    // Quadrant of the full cycle, taken from the top two phase-index bits
    typedef enum logic [1:0] {
        QD_RISE     = 2'd0,
        QD_FALL     = 2'd1,
        QD_NEG_RISE = 2'd2,
        QD_NEG_FALL = 2'd3
    } quad_e;

    typedef struct packed {
        logic mirror;   // read the table backwards
        logic negate;   // flip the sign of the table value
    } fold_t;

    function automatic fold_t fold_of(input quad_e q);
        fold_t f;
        f.mirror = (q == QD_FALL) || (q == QD_NEG_FALL);
        f.negate = (q == QD_NEG_RISE) || (q == QD_NEG_FALL);
        return f;
    endfunction

    // Quarter-wave magnitude at the centre of table slot k
    function automatic int quarter_sine(input int k, input int lut_aw, input int amp_w);
        real ang;
        real v;
        ang = 6.283185307179586 * (real'(k) + 0.5) / real'(4 * (1 << lut_aw));
        v   = real'((1 << (amp_w - 1)) - 1) * $sin(ang);
        return int'($floor(v + 0.5));
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = 25
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ce,
    input  logic signed [PHASE_W-1:0] step,
    output logic        [PHASE_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (ce)
            phase <= phase + $unsigned(step);
    end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
    import nco_mix_pkg::*;
#(
    parameter int PHASE_W = 25,
    parameter int LUT_AW  = 10,
    parameter int AMP_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce,
    input  logic [PHASE_W-1:0]       phase,
    output logic signed [AMP_W-1:0]  sin_amp,
    output logic signed [AMP_W-1:0]  cos_amp
);
    localparam int DEPTH = 1 << LUT_AW;
    localparam int IDX_W = LUT_AW + 2;

    logic [AMP_W-2:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam int QV = quarter_sine(g, LUT_AW, AMP_W);
        assign rom[g] = QV[AMP_W-2:0];
    end

    logic [IDX_W-1:0]  idx;
    logic [LUT_AW-1:0] slot;
    quad_e             s_quad, c_quad;
    fold_t             s_fold, c_fold;

    assign idx    = phase[PHASE_W-1 -: IDX_W];
    assign slot   = idx[LUT_AW-1:0];
    assign s_quad = quad_e'(idx[IDX_W-1 -: 2]);
    assign c_quad = quad_e'(idx[IDX_W-1 -: 2] + 2'd1);   // quarter turn ahead
    assign s_fold = fold_of(s_quad);
    assign c_fold = fold_of(c_quad);

    // stage 1: folded table addresses and sign flags
    logic [LUT_AW-1:0] s_addr, c_addr;
    logic              s_neg, c_neg;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_addr <= '0;
            c_addr <= '0;
            s_neg  <= 1'b0;
            c_neg  <= 1'b0;
        end else if (ce) begin
            s_addr <= s_fold.mirror ? ~slot : slot;
            c_addr <= c_fold.mirror ? ~slot : slot;
            s_neg  <= s_fold.negate;
            c_neg  <= c_fold.negate;
        end
    end

    // stage 2: table read and sign restore
    logic signed [AMP_W-1:0] s_mag, c_mag;
    assign s_mag = $signed({1'b0, rom[s_addr]});
    assign c_mag = $signed({1'b0, rom[c_addr]});

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_amp <= '0;
            cos_amp <= '0;
        end else if (ce) begin
            sin_amp <= s_neg ? -s_mag : s_mag;
            cos_amp <= c_neg ? -c_mag : c_mag;
        end
    end
endmodule

// File: rtl/nco_mix_round.sv
module nco_mix_round #(
    parameter int AMP_W = 16,
    parameter int IN_W  = 14,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic signed [AMP_W-1:0] amp,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);
    localparam int PW   = AMP_W + IN_W;
    localparam int DROP = PW - 1 - OUT_W;   // magnitude fits in PW-1 bits

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;

    always_ff @(posedge clk) begin
        if (rst)
            prod <= '0;
        else if (ce)
            prod <= amp * x;
    end

    assign biased = prod + (PW'(1) <<< (DROP - 1));

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (ce)
            y <= biased[DROP +: OUT_W];
    end
endmodule

// File: rtl/nco_downmixer.sv
module nco_downmixer
    import nco_mix_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF,
    parameter int LUT_AW  = LUT_AW_DEF,
    parameter int AMP_W   = AMP_W_DEF,
    parameter int IN_W    = IN_W_DEF,
    parameter int OUT_W   = OUT_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clk_en,
    input  logic signed [PHASE_W-1:0] tune_word,
    input  logic signed [IN_W-1:0]    adc_data,
    input  logic                      adc_valid,
    output logic signed [OUT_W-1:0]   i_out,
    output logic signed [OUT_W-1:0]   q_out,
    output logic                      iq_valid
);
    localparam int NCH = 2;   // 0: in-phase, 1: quadrature

    logic [PHASE_W-1:0]      phase_q;
    logic signed [AMP_W-1:0] sin_amp, cos_amp;

    nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .ce    (clk_en),
        .step  (tune_word),
        .phase (phase_q)
    );

    nco_sincos #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_osc (
        .clk     (clk),
        .rst     (rst),
        .ce      (clk_en),
        .phase   (phase_q),
        .sin_amp (sin_amp),
        .cos_amp (cos_amp)
    );

    // sample and valid follow the oscillator's two stages
    logic signed [IN_W-1:0] x_s1, x_s2;
    logic [PIPE_LAT-1:0]    v_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_s1   <= '0;
            x_s2   <= '0;
            v_pipe <= '0;
        end else if (clk_en) begin
            x_s1   <= adc_data;
            x_s2   <= x_s1;
            v_pipe <= {v_pipe[PIPE_LAT-2:0], adc_valid};
        end
    end

    logic signed [AMP_W-1:0] amp_ch [NCH];
    logic signed [OUT_W-1:0] y_ch   [NCH];

    assign amp_ch[0] = cos_amp;
    assign amp_ch[1] = sin_amp;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        nco_mix_round #(.AMP_W(AMP_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_mul (
            .clk (clk),
            .rst (rst),
            .ce  (clk_en),
            .amp (amp_ch[c]),
            .x   (x_s2),
            .y   (y_ch[c])
        );
    end

    assign i_out    = y_ch[0];
    assign q_out    = y_ch[1];
    assign iq_valid = v_pipe[PIPE_LAT-1];
endmodule

// File: rtl/nco_downmixer_chk.sv
module nco_downmixer_chk #(
    parameter int IN_W  = 14,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clk_en,
    input logic signed [IN_W-1:0]  adc_data,
    input logic                    adc_valid,
    input logic signed [OUT_W-1:0] i_out,
    input logic signed [OUT_W-1:0] q_out,
    input logic                    iq_valid
);
    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic [3:0] vsh;
    logic [3:0] zsh;

    always_ff @(posedge clk) begin
        if (rst) begin
            vsh <= '0;
            zsh <= '0;
        end else if (clk_en) begin
            vsh <= {vsh[2:0], adc_valid};
            zsh <= {zsh[2:0], (adc_data == '0)};
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!iq_valid && i_out == '0 && q_out == '0));

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        iq_valid == vsh[3]);

    // R6
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(i_out) && $stable(q_out) && $stable(iq_valid)));

    // R4
    zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (iq_valid && zsh[3]) |-> (i_out == '0 && q_out == '0));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        iq_valid |-> (i_out != MOST_NEG && q_out != MOST_NEG));
endmodule

bind nco_downmixer nco_downmixer_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .adc_data  (adc_data),
    .adc_valid (adc_valid),
    .i_out     (i_out),
    .q_out     (q_out),
    .iq_valid  (iq_valid)
);

// File: tb/sim_nco_downmixer.sv
module sim_nco_downmixer;

    localparam int PW = 25;
    localparam int XW = 14;
    localparam int OW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 clk_en = 1'b0;
    logic signed [PW-1:0] tune_word = '0;
    logic signed [XW-1:0] adc_data = '0;
    logic                 adc_valid = 1'b0;
    logic signed [OW-1:0] i_out, q_out;
    logic                 iq_valid;

    always #2.5 clk = ~clk;

    nco_downmixer u0 (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .tune_word (tune_word),
        .adc_data  (adc_data),
        .adc_valid (adc_valid),
        .i_out     (i_out),
        .q_out     (q_out),
        .iq_valid  (iq_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // independent model
    longint mphase = 0;
    bit     ev [4];
    longint ei [4];
    longint eq [4];

    function automatic longint sine_of(input longint p);
        real s, m;
        s = $sin(6.283185307179586 * (real'(p) + 0.5) / 4096.0);
        m = $floor(32767.0 * (s < 0.0 ? -s : s) + 0.5);
        return (s < 0.0) ? -longint'(m) : longint'(m);
    endfunction

    function automatic longint rnd(input longint prod);
        return (prod + 4096) >>> 13;
    endfunction

    task automatic model_clear();
        mphase = 0;
        for (int k = 0; k < 4; k++) begin
            ev[k] = 0; ei[k] = 0; eq[k] = 0;
        end
    endtask

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // one clock: drive at negedge, update model at the edge, compare at next negedge
    task automatic step(input bit ce_i, input bit v_i, input int x_i, input longint tw_i, input string tag);
        longint p, s, c;
        clk_en    = ce_i;
        adc_valid = v_i;
        adc_data  = XW'(x_i);
        tune_word = PW'(tw_i);
        @(posedge clk);
        if (ce_i) begin
            p = (mphase >> 13) & 4095;
            s = sine_of(p);
            c = sine_of((p + 1024) % 4096);
            for (int k = 3; k > 0; k--) begin
                ev[k] = ev[k-1]; ei[k] = ei[k-1]; eq[k] = eq[k-1];
            end
            ev[0] = v_i;
            ei[0] = rnd(c * longint'(x_i));
            eq[0] = rnd(s * longint'(x_i));
            mphase = (mphase + tw_i) & ((longint'(1) << PW) - 1);
        end
        @(negedge clk);
        check(tag, "iq_valid", longint'(iq_valid), longint'(ev[3]));
        if (ev[3]) begin
            check(tag, "i_out", longint'(i_out), ei[3]);
            check(tag, "q_out", longint'(q_out), eq[3]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clk_en = 1'b1;
        adc_valid = 1'b1;
        adc_data = 14'sd1000;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1", "iq_valid in reset", longint'(iq_valid), 0);
        check("R1", "i_out in reset", longint'(i_out), 0);
        check("R1", "q_out in reset", longint'(q_out), 0);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic t_tone();
        do_reset();
        for (int n = 0; n < 40; n++)
            step(1, 1, 4000 - 150 * n, 262144, "R2,R3,R4");
    endtask

    task automatic t_quarter();
        do_reset();
        for (int n = 0; n < 12; n++)
            step(1, 1, 5000, 8388608, "R3");
    endtask

    task automatic t_latency();
        do_reset();
        for (int n = 0; n < 10; n++)
            step(1, (n == 2), 3000, 100000, "R5");
    endtask

    task automatic t_negative();
        do_reset();
        for (int n = 0; n < 30; n++)
            step(1, 1, 6000, -262144 - 4321, "R8");
    endtask

    task automatic t_retune();
        do_reset();
        for (int n = 0; n < 36; n++)
            step(1, 1, 2500 + 37 * n, (n < 12) ? 524288 : (n < 24) ? -1000000 : 3, "R7");
    endtask

    task automatic t_enable_gaps();
        do_reset();
        for (int n = 0; n < 40; n++)
            step((n % 3) != 1, 1, -3000 + 111 * n, 700000, "R6");
    endtask

    task automatic t_valid_gaps();
        do_reset();
        for (int n = 0; n < 30; n++)
            step(1, (n % 4) != 2, 7000 - 200 * n, 300001, "R9");
    endtask

    task automatic t_fullscale();
        do_reset();
        for (int n = 0; n < 6; n++)
            step(1, 1, -8192, 0, "R10");
        for (int n = 0; n < 6; n++)
            step(1, 1, 8191, 0, "R10");
        for (int n = 0; n < 20; n++)
            step(1, 1, (n % 2) ? 8191 : -8192, 1 << 20, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_tone();
        t_quarter();
        t_latency();
        t_negative();
        t_retune();
        t_enable_gaps();
        t_valid_gaps();
        t_fullscale();
        // R1: the first cycle after a mid-run reset is clean
        do_reset();
        clk_en = 1'b0;
        @(negedge clk);
        check("R1", "iq_valid after reset", longint'(iq_valid), 0);
        check("R1", "i_out after reset", longint'(i_out), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule